// File: doc/BRIEF.md
# Real-Time Clock Timebase with Guarded Configuration Registers

This block produces a one-second-style time base from a fast input clock and keeps a 32-bit running seconds count. A down-counting prescaler with a 20-bit reload value divides the clock. Each time the prescaler wraps it emits a tick. The tick advances the seconds counter and raises a sticky per-tick event flag. The seconds counter is compared against a 32-bit alarm value, and its wrap past the all-ones value raises an overflow flag. Software reaches all state through a 16-bit register interface with a 3-bit address. Reads are combinational, and writes take effect on a clock edge.

A small write guard protects the configuration. Every accepted write opens a busy window. The guard state machine has two states, `GS_READY` and `GS_BUSY`. The transition from `GS_READY` to `GS_BUSY` happens on an accepted write. `GS_BUSY` steps its counter and returns to `GS_READY` once `BUSY_CYCLES` cycles have elapsed. The return raises a sync-done flag. While the guard is in `GS_BUSY`, the ready status bit reads 0 and every write is discarded. The event flags can only be set by hardware and only cleared by software. Software clears a flag by writing 0 to its bit. A bus-clock-enable input freezes the flag register: while it is low, flags are neither set nor cleared.

Register map (addr: content):
- 0, control: bit0 tick-interrupt enable, bit1 alarm-interrupt enable, bit2 overflow-interrupt enable.
- 1, flags: bit0 tick flag, bit1 alarm flag, bit2 overflow flag, bit3 sync-done flag, bit5 ready (read-only).
- 2, reload low: reload value bits 15:0.
- 3, reload high: reload value bits 19:16 in bits 3:0. Bits 15:4 read as zero.
- 4, count low.
- 5, count high.
- 6, alarm low.
- 7, alarm high.

Top module: `rtcq_timebase`

## Requirements
- R1: The tick period is reload+1 clock cycles. A write to either reload register restarts the division from the new value. Reload-high bits 3:0 hold reload bits 19:16, and bits 15:4 read as 0.
- R2: The seconds counter increments by one on each tick. Writes to addr 4 and addr 5 load its low and high halves, and read-back returns the loaded value.
- R3: A write is accepted only while ready (flags bit5) is 1. After the accepting edge, ready reads 0 for exactly 3 cycles (`BUSY_CYCLES`), then 1 again, and attempts made during the window do not extend it.
- R4: Writes attempted while ready is 0 change no register.
- R5: The tick flag (flags bit0) sets on every tick.
- R6: The alarm flag (flags bit1) sets on the tick that makes the counter equal to the alarm value, and not before.
- R7: The overflow flag (flags bit2) sets when the counter wraps from 0xFFFFFFFF to 0.
- R8: The sync-done flag (flags bit3) sets when a busy window ends.
- R9: A flag is cleared only by writing 0 to its bit at addr 1. Writing 1 leaves it unchanged.
- R10: irq is 1 exactly when some source among tick, alarm and overflow has both its flag and its enable at 1. The sync-done flag never drives irq.
- R11: In reset, the enables are 0, all flags are 0, ready is 1, the reload, count and alarm registers are 0, and irq is 0.
- R12: While bus_clk_en is 0, the flags neither set nor clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives the prescaler and all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk_en | input | 1 | High while the bus clock runs; low freezes the flags |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
- **Register reads:** A register write lands on the accepting edge. Read-back is combinational, so the bench samples it at the next falling edge.
- **Ready and sync-done:** Ready drops at the falling edge after the accepting edge and stays low on the following two. It returns, together with the sync-done flag, at the fourth falling edge. The bench probes every one of those edges.
- **Ticks and flags:** A tick changes the counter and sets the flags on the same edge. The bench therefore polls the count at every falling edge and reads the flags at the first edge a new count appears. This is also how it tests the alarm and overflow boundaries one value before and at the event.
- **Period measurement:** Tick periods are measured as edge counts between two count changes and compared with reload+1.

// File: rtl/rtcq_pkg.sv
package rtcq_pkg;

    localparam int BUS_W   = 16;
    localparam int CNT_W   = 2 * BUS_W;
    localparam int NFLAG   = 4;
    localparam int NSRC    = 3;

    localparam int FB_TICK  = 0;
    localparam int FB_ALARM = 1;
    localparam int FB_OVF   = 2;
    localparam int FB_SYNC  = 3;
    localparam int FB_READY = 5;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_FLAGS   = 3'd1,
        RA_PRL_LO  = 3'd2,
        RA_PRL_HI  = 3'd3,
        RA_CNT_LO  = 3'd4,
        RA_CNT_HI  = 3'd5,
        RA_ALM_LO  = 3'd6,
        RA_ALM_HI  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        GS_READY = 1'b0,
        GS_BUSY  = 1'b1
    } guard_state_e;

endpackage

// File: rtl/rtcq_wr_guard.sv
module rtcq_wr_guard
    import rtcq_pkg::*;
#(
    parameter int BUSY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic wr_accept,
    output logic ready,
    output logic done
);
    localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

    guard_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GS_READY: begin
                if (wr_req) begin
                    state_d = GS_BUSY;
                    cnt_d   = '0;
                end
            end
            GS_BUSY: begin
                if (cnt_q == LAST) begin
                    state_d = GS_READY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        ready     = (state_q == GS_READY);
        wr_accept = ready && wr_req;
        done      = (state_q == GS_BUSY) && (cnt_q == LAST);
    end

    a_r3_ready_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr_req));
    a_r3_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
endmodule

// File: rtl/rtcq_prescaler.sv
module rtcq_prescaler #(
    parameter int PRL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRL_W-1:0] reload_val,
    output logic             tick
);
    logic [PRL_W-1:0] cnt_q;

    always_comb tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r1_reload_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || restart) |=> (cnt_q == $past(reload_val)));
    a_r1_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rtcq_seconds.sv
module rtcq_seconds
    import rtcq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count,
    output logic             alm_evt,
    output logic             ovf_evt
);
    localparam int NHALF = CNT_W / BUS_W;

    logic [CNT_W-1:0] count_inc;
    logic [CNT_W-1:0] count_d;
    logic [NHALF-1:0] ld_half;
    logic             any_ld;

    always_comb begin
        ld_half   = {ld_hi, ld_lo};
        any_ld    = |ld_half;
        count_inc = count + CNT_W'(1);
        alm_evt   = tick && !any_ld && (count_inc == alarm);
        ovf_evt   = tick && !any_ld && (&count);
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        always_comb begin
            if (ld_half[h]) begin
                count_d[h*BUS_W +: BUS_W] = wdata;
            end else if (tick && !any_ld) begin
                count_d[h*BUS_W +: BUS_W] = count_inc[h*BUS_W +: BUS_W];
            end else begin
                count_d[h*BUS_W +: BUS_W] = count[h*BUS_W +: BUS_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_d;
        end
    end

    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_lo && !ld_hi) |=> (count == $past(count) + CNT_W'(1)));
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (count == '0));
    a_r6_alarm_match: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |=> (count == $past(alarm)));
endmodule

// File: rtl/rtcq_timebase.sv
module rtcq_timebase
    import rtcq_pkg::*;
#(
    parameter int PRL_W       = 20,
    parameter int BUSY_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_en,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);
    localparam int PHI_W = PRL_W - BUS_W;

    logic             wr_acc, ready, guard_done, tick;
    logic             alm_evt, ovf_evt;
    logic [NSRC-1:0]  ie_q;
    logic [NFLAG-1:0] flags_q, flags_d, flag_set, flag_keep;
    logic [PRL_W-1:0] prl_q, prl_d;
    logic [CNT_W-1:0] alm_q, alm_d, count;
    logic             we_ctrl, we_flags, we_plo, we_phi, we_clo, we_chi, we_alo, we_ahi;

    rtcq_wr_guard #(.BUSY_CYCLES(BUSY_CYCLES)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_en),
        .wr_accept(wr_acc), .ready(ready), .done(guard_done)
    );

    always_comb begin
        we_ctrl  = wr_acc && (addr == RA_CTRL);
        we_flags = wr_acc && (addr == RA_FLAGS);
        we_plo   = wr_acc && (addr == RA_PRL_LO);
        we_phi   = wr_acc && (addr == RA_PRL_HI);
        we_clo   = wr_acc && (addr == RA_CNT_LO);
        we_chi   = wr_acc && (addr == RA_CNT_HI);
        we_alo   = wr_acc && (addr == RA_ALM_LO);
        we_ahi   = wr_acc && (addr == RA_ALM_HI);
    end

    always_comb begin
        prl_d = prl_q;
        if (we_plo) prl_d[BUS_W-1:0]     = wdata;
        if (we_phi) prl_d[PRL_W-1:BUS_W] = wdata[PHI_W-1:0];
        alm_d = alm_q;
        if (we_alo) alm_d[BUS_W-1:0]     = wdata;
        if (we_ahi) alm_d[CNT_W-1:BUS_W] = wdata;
    end

    rtcq_prescaler #(.PRL_W(PRL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(we_plo || we_phi),
        .reload_val(prl_d), .tick(tick)
    );

    rtcq_seconds u_secs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_lo(we_clo), .ld_hi(we_chi),
        .wdata(wdata), .alarm(alm_q), .count(count),
        .alm_evt(alm_evt), .ovf_evt(ovf_evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= '0;
            prl_q <= '0;
            alm_q <= '0;
        end else begin
            if (we_ctrl) ie_q <= wdata[NSRC-1:0];
            prl_q <= prl_d;
            alm_q <= alm_d;
        end
    end

    // flags: hardware sets, software clears with a zero bit
    always_comb begin
        flag_set            = '0;
        flag_set[FB_TICK]   = tick;
        flag_set[FB_ALARM]  = alm_evt;
        flag_set[FB_OVF]    = ovf_evt;
        flag_set[FB_SYNC]   = guard_done;
        flag_keep           = we_flags ? wdata[NFLAG-1:0] : '1;
        flags_d             = (flags_q & flag_keep) | flag_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (bus_clk_en) begin
            flags_q <= flags_d;
        end
    end

    always_comb irq = |(flags_q[NSRC-1:0] & ie_q);

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            RA_CTRL:   rdata[NSRC-1:0] = ie_q;
            RA_FLAGS: begin
                rdata[NFLAG-1:0] = flags_q;
                rdata[FB_READY]  = ready;
            end
            RA_PRL_LO: rdata = prl_q[BUS_W-1:0];
            RA_PRL_HI: rdata[PHI_W-1:0] = prl_q[PRL_W-1:BUS_W];
            RA_CNT_LO: rdata = count[BUS_W-1:0];
            RA_CNT_HI: rdata = count[CNT_W-1:BUS_W];
            RA_ALM_LO: rdata = alm_q[BUS_W-1:0];
            RA_ALM_HI: rdata = alm_q[CNT_W-1:BUS_W];
        endcase
    end

    a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ready) |=> ($stable(ie_q) && $stable(prl_q) && $stable(alm_q)));
    a_r12_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clk_en |=> $stable(flags_q));
    a_r5_tick_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FB_TICK]) |-> $past(tick));
    a_r8_sync_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FB_SYNC]) |-> $past(guard_done));
    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ready && (addr == RA_FLAGS))
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: tb/tb_rtcq_timebase.sv
module tb_rtcq_timebase;
    import rtcq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_clk_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtcq_timebase dut (
        .clk(clk), .rst_n(rst_n), .bus_clk_en(bus_clk_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_cnt(output logic [31:0] c);
        logic [15:0] v;
        rd(RA_CNT_LO, v); c[15:0]  = v;
        rd(RA_CNT_HI, v); c[31:16] = v;
    endtask

    task automatic wait_lo(input logic [15:0] target, output bit ok);
        logic [15:0] v;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(RA_CNT_LO, v);
            if (v == target) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(output int n);
        logic [15:0] v0, v1;
        rd(RA_CNT_LO, v0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); rd(RA_CNT_LO, v1);
            if (v1 != v0) break;
        end
        v0 = v1;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); n++; rd(RA_CNT_LO, v1);
            if (v1 != v0) break;
        end
    endtask

    task automatic irq_sweep(input logic [2:0] fl, input string tag);
        for (int ie = 0; ie < 8; ie++) begin
            wr(RA_CTRL, 16'(ie));
            chk("R10", tag, {31'd0, irq}, {31'd0, ((3'(ie) & fl) != 3'd0)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] c;
        bit ok;
        int n;

        // R11: reset state
        repeat (3) @(negedge clk);
        rd(RA_CTRL, v);   chk("R11", "ctrl", {16'd0, v}, 32'h0);
        rd(RA_FLAGS, v);  chk("R11", "flags", {16'd0, v}, 32'h20);
        rd(RA_PRL_LO, v); chk("R11", "reload lo", {16'd0, v}, 32'h0);
        rd(RA_PRL_HI, v); chk("R11", "reload hi", {16'd0, v}, 32'h0);
        rd_cnt(c);        chk("R11", "count", c, 32'h0);
        rd(RA_ALM_LO, v); chk("R11", "alarm lo", {16'd0, v}, 32'h0);
        chk("R11", "irq", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R8: busy window length and sync-done flag
        wr_en = 1'b1; addr = RA_CTRL; wdata = 16'h5;
        @(negedge clk);
        wr_en = 1'b0;
        rd(RA_FLAGS, v); chk("R3", "ready n1", {31'd0, v[5]}, 32'h0);
        @(negedge clk);
        rd(RA_FLAGS, v); chk("R3", "ready n2", {31'd0, v[5]}, 32'h0);
        @(negedge clk);
        rd(RA_FLAGS, v); chk("R3", "ready n3", {31'd0, v[5]}, 32'h0);
        chk("R8", "sync before end", {31'd0, v[3]}, 32'h0);
        @(negedge clk);
        rd(RA_FLAGS, v); chk("R3", "ready n4", {31'd0, v[5]}, 32'h1);
        chk("R8", "sync at end", {31'd0, v[3]}, 32'h1);
        rd(RA_CTRL, v); chk("R3", "accepted write", {16'd0, v}, 32'h5);

        // R4: attempts inside the window are dropped, window not extended
        wr_en = 1'b1; addr = RA_CTRL; wdata = 16'h3;
        @(negedge clk); wdata = 16'h6;
        @(negedge clk); wdata = 16'h7;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        rd(RA_FLAGS, v); chk("R3", "ready after attempts", {31'd0, v[5]}, 32'h1);
        rd(RA_CTRL, v);  chk("R4", "ctrl kept", {16'd0, v}, 32'h3);
        wr(RA_CTRL, 16'h0);

        // R1: reload high masking and read-back
        wr(RA_PRL_HI, 16'hFFFF);
        rd(RA_PRL_HI, v); chk("R1", "reload hi mask", {16'd0, v}, 32'h000F);
        wr(RA_PRL_HI, 16'h0);
        rd(RA_PRL_HI, v); chk("R1", "reload hi zero", {16'd0, v}, 32'h0);
        wr(RA_PRL_LO, 16'hABCD);
        rd(RA_PRL_LO, v); chk("R1", "reload lo", {16'd0, v}, 32'hABCD);

        // R1: period sweep
        for (int p = 0; p < 10; p++) begin
            wr(RA_PRL_LO, 16'(p));
            measure(n); chk("R1", "period a", 32'(n), 32'(p + 1));
            measure(n); chk("R1", "period b", 32'(n), 32'(p + 1));
        end

        // R2: counter load and step
        wr(RA_PRL_LO, 16'd40);
        wr(RA_CNT_HI, 16'h1234);
        wr(RA_CNT_LO, 16'h0100);
        rd_cnt(c); chk("R2", "loaded", c, 32'h12340100);
        wait_lo(16'h0101, ok); chk("R2", "step seen", {31'd0, ok}, 32'h1);
        rd_cnt(c); chk("R2", "stepped", c, 32'h12340101);

        // R6: alarm boundary
        wr(RA_PRL_LO, 16'd3);
        wr(RA_ALM_HI, 16'h0);
        wr(RA_ALM_LO, 16'd20);
        wr(RA_CNT_HI, 16'h0);
        wr(RA_CNT_LO, 16'd10);
        wr(RA_FLAGS, 16'h0);
        wait_lo(16'd19, ok);
        rd(RA_FLAGS, v); chk("R6", "alarm before", {31'd0, v[1]}, 32'h0);
        wait_lo(16'd20, ok);
        rd(RA_FLAGS, v); chk("R6", "alarm at match", {31'd0, v[1]}, 32'h1);
        chk("R5", "tick flag", {31'd0, v[0]}, 32'h1);

        // R7: overflow boundary
        wr(RA_CNT_HI, 16'hFFFF);
        wr(RA_CNT_LO, 16'hFFF0);
        wr(RA_FLAGS, 16'h0);
        wait_lo(16'hFFFF, ok);
        rd(RA_FLAGS, v); chk("R7", "ovf before", {31'd0, v[2]}, 32'h0);
        rd(RA_CNT_HI, v); chk("R7", "hi before", {16'd0, v}, 32'hFFFF);
        wait_lo(16'h0000, ok);
        rd(RA_FLAGS, v); chk("R7", "ovf at wrap", {31'd0, v[2]}, 32'h1);
        rd(RA_CNT_HI, v); chk("R7", "hi after wrap", {16'd0, v}, 32'h0);

        // R5-R7 together, then R9 / R10 flag clearing and irq sweeps
        wr(RA_PRL_LO, 16'd1);
        wr(RA_ALM_LO, 16'd3);
        wr(RA_CNT_HI, 16'hFFFF);
        wr(RA_CNT_LO, 16'hFFFE);
        wait_lo(16'd5, ok); chk("R6", "reach 5", {31'd0, ok}, 32'h1);
        wr(RA_PRL_LO, 16'hFFFF);
        rd(RA_FLAGS, v); chk("R7", "all flags", {28'd0, v[3:0]}, 32'hF);
        irq_sweep(3'b111, "all sources");
        wr(RA_FLAGS, 16'hFFFD);
        rd(RA_FLAGS, v); chk("R9", "clear alarm only", {28'd0, v[3:0]}, 32'hD);
        irq_sweep(3'b101, "tick+ovf");
        wr(RA_FLAGS, 16'hFFFC);
        rd(RA_FLAGS, v); chk("R9", "clear tick", {28'd0, v[3:0]}, 32'hC);
        irq_sweep(3'b100, "ovf only");
        wr(RA_FLAGS, 16'h0000);
        rd(RA_FLAGS, v); chk("R9", "sync re-set only", {28'd0, v[3:0]}, 32'h8);
        irq_sweep(3'b000, "sync only");
        wr(RA_CTRL, 16'h0);

        // R12: frozen flags
        @(negedge clk); bus_clk_en = 1'b0;
        wr(RA_PRL_LO, 16'd1);
        repeat (10) @(negedge clk);
        rd(RA_FLAGS, v); chk("R12", "no set while frozen", {28'd0, v[3:0]}, 32'h8);
        wr(RA_FLAGS, 16'h0);
        rd(RA_FLAGS, v); chk("R12", "no clear while frozen", {28'd0, v[3:0]}, 32'h8);
        bus_clk_en = 1'b1;
        repeat (4) @(negedge clk);
        rd(RA_FLAGS, v); chk("R12", "tick after thaw", {31'd0, v[0]}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule